// File: doc/BRIEF.md
# Watchdog Timer with Slow-Clock Counter and Key-Protected Configuration

This block is a watchdog that counts in its own low-speed clock domain while software reaches it from the bus clock domain. Software writes 16-bit command keys to one register. These keys start the watchdog, refresh it, or open the divider and reload registers for writing. A power-of-two divider paces a 12-bit down-counter. If software fails to refresh the counter before it runs out, the block raises a reset request. The request stays high until the block is reset.

Each change to the configuration and each command crosses between the domains through a toggle handshake. Software can read a busy flag for each configuration register while its new value is still in flight. A value written to a register is used by the counter only after the slow domain acknowledges it. A hardware enable pin can start the watchdog straight out of reset, with no key written. In that case it uses the default divider (/4) and reload (0xFFF).

Top module: `wdog_top`

## Requirements
- R1: After reset, address 1 (divider code) reads 0, address 2 (reload) reads 0xFFF, address 3 (status) reads 0, and `resetReq` is low. It stays low indefinitely unless the watchdog is started.
- R2: The divider (address 1, bits [2:0]) and reload (address 2, bits [11:0]) registers accept a write only after key 0x5555 has been written to address 0. A write made while locked leaves the read-back value unchanged.
- R3: Writing any key value other than 0x5555 to address 0 locks the configuration registers again. This includes the start and refresh keys.
- R4: Status bit 0 reads 1 while a divider update is in flight, and bit 1 reads 1 while a reload update is in flight. Both updates may be in flight at once. Each flag clears within 5 slow-clock cycles of the write.
- R5: A write to the divider or reload register while that register's busy flag is set is ignored.
- R6: Key 0xCCCC starts the watchdog. The counter loads the reload value R and decrements once per 2^(code+2) slow cycles. `resetReq` rises (R+1)·2^(code+2) slow cycles after the command reaches the slow domain, plus up to 5 cycles of crossing latency.
- R7: Key 0xAAAA reloads the counter from the reload register and restarts the divider phase. Refreshing regularly keeps `resetReq` low.
- R8: Once `resetReq` is high, it stays high until `rstN` is asserted. Refresh or start keys have no effect on it.
- R9: With `hwStart` high, the watchdog runs from reset with no key, using divide-by-4 and a count of 0xFFF. It expires after about 16384 slow cycles.
- R10: Divider codes 0 to 6 select /4 to /256. Code 7 also selects /256.
- R11: The reload value is masked to 12 bits. Writing 0x1005 reads back as 0x005.
- R12: A refresh key written before the watchdog has started does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock for the register interface |
| slowClk | input | 1 | Low-speed clock for the counter |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| hwStart | input | 1 | Hardware enable: run without a start key |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 key, 1 divider, 2 reload, 3 status |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` (the key register reads 0) |
| resetReq | output | 1 | Sticky system reset request |

## Verification
Two transfers can be in flight across the domain boundary in the same cycle: a divider update and a reload update. The bench writes the divider code and then the reload value a few bus cycles apart. It then reads the status register while the first transfer has not yet finished. The bench judges the case by three things: both flags read 1 together, a further write to the busy divider is dropped, and both flags clear before the next idle wait ends. Afterwards, the expiry time measured with the new divider and reload together shows that both values reached the counter.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int KEY_W    = 16;
  localparam int CNT_W    = 12;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 6;                 // /256
  localparam int DIV_W    = MAX_CODE + 2;      // divider phase counter width
  localparam int ADDR_W   = 2;

  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;

  localparam logic [ADDR_W-1:0] REG_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_LOAD = 2'd2;
  localparam logic [ADDR_W-1:0] REG_STAT = 2'd3;

  // channel index of each handshake
  localparam int CH_CMD  = 0;
  localparam int CH_DIV  = 1;
  localparam int CH_LOAD = 2;
  localparam int N_CH    = 3;

  // strobes and held data passed from the bus-side control to the counter
  typedef struct packed {
    logic              loadTgl;
    logic              divTgl;
    logic              cmdTgl;
    logic              cmdStart;
    logic [CODE_W-1:0] divCode;
    logic [CNT_W-1:0]  loadVal;
  } xfer_t;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], dIn[b]};
    end
    assign dOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              busClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  wrData,
  input  logic [N_CH-1:0]   ackRaw,
  output logic [KEY_W-1:0]  rdData,
  output xfer_t             xfer
);
  logic [N_CH-1:0]   ackSync;
  logic              unlocked;
  logic              cmdTgl, cmdStart, divTgl, loadTgl;
  logic [CODE_W-1:0] divReg;
  logic [CNT_W-1:0]  loadReg;
  logic              cmdBusy, divBusy, loadBusy;
  logic              keyWr, divWr, loadWr, isCmdKey;

  wdog_sync #(.WIDTH(N_CH), .STAGES(2)) u_ackSync (
    .clk(busClk), .rstN(rstN), .dIn(ackRaw), .dOut(ackSync)
  );

  assign cmdBusy  = cmdTgl  ^ ackSync[CH_CMD];
  assign divBusy  = divTgl  ^ ackSync[CH_DIV];
  assign loadBusy = loadTgl ^ ackSync[CH_LOAD];

  assign keyWr    = wrEn && (addr == REG_KEY);
  assign isCmdKey = (wrData == KEY_START) || (wrData == KEY_FEED);
  assign divWr    = wrEn && (addr == REG_DIV)  && unlocked && !divBusy;
  assign loadWr   = wrEn && (addr == REG_LOAD) && unlocked && !loadBusy;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      cmdTgl   <= 1'b0;
      cmdStart <= 1'b0;
      divTgl   <= 1'b0;
      loadTgl  <= 1'b0;
      divReg   <= '0;
      loadReg  <= '1;
    end else begin
      if (keyWr) begin
        unlocked <= (wrData == KEY_OPEN);
        if (isCmdKey && !cmdBusy) begin
          cmdTgl   <= ~cmdTgl;
          cmdStart <= (wrData == KEY_START);
        end
      end
      if (divWr) begin
        divReg <= wrData[CODE_W-1:0];
        divTgl <= ~divTgl;
      end
      if (loadWr) begin
        loadReg <= wrData[CNT_W-1:0];
        loadTgl <= ~loadTgl;
      end
    end
  end

  always_comb begin
    unique case (addr)
      REG_DIV:  rdData = KEY_W'(divReg);
      REG_LOAD: rdData = KEY_W'(loadReg);
      REG_STAT: rdData = KEY_W'({loadBusy, divBusy});
      default:  rdData = '0;
    endcase
  end

  always_comb begin
    xfer.loadTgl  = loadTgl;
    xfer.divTgl   = divTgl;
    xfer.cmdTgl   = cmdTgl;
    xfer.cmdStart = cmdStart;
    xfer.divCode  = divReg;
    xfer.loadVal  = loadReg;
  end

  // R2: a locked write never changes the divider register
  p_locked_div_r2: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && addr == REG_DIV && !unlocked) |=> $stable(divReg));
  // R5: a write while the reload transfer is in flight is dropped
  p_busy_load_r5: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && addr == REG_LOAD && loadBusy) |=> $stable(loadReg));
  // R3: any key other than the unlock key closes the registers
  p_relock_r3: assert property (@(posedge busClk) disable iff (!rstN)
    (wrEn && addr == REG_KEY && wrData != KEY_OPEN) |=> !unlocked);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic            slowClk,
  input  logic            rstN,
  input  logic            hwStart,
  input  xfer_t           xfer,
  output logic [N_CH-1:0] ackTgl,
  output logic            resetReq
);
  logic [N_CH-1:0]   synced, seen, evt;
  logic [CODE_W-1:0] divSlow, effCode;
  logic [CNT_W-1:0]  loadSlow, nextLoad, cnt;
  logic [DIV_W-1:0]  preCnt, divLimit;
  logic              running, tick;

  wdog_sync #(.WIDTH(N_CH), .STAGES(2)) u_reqSync (
    .clk(slowClk), .rstN(rstN),
    .dIn({xfer.loadTgl, xfer.divTgl, xfer.cmdTgl}), .dOut(synced)
  );

  assign evt      = synced ^ seen;
  assign ackTgl   = seen;
  assign effCode  = (divSlow > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : divSlow;
  assign divLimit = ~({DIV_W{1'b1}} << ({1'b0, effCode} + 4'd2));
  assign tick     = preCnt >= divLimit;
  assign nextLoad = evt[CH_LOAD] ? xfer.loadVal : loadSlow;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      seen     <= '0;
      divSlow  <= '0;
      loadSlow <= '1;
      running  <= 1'b0;
      preCnt   <= '0;
      cnt      <= '1;
      resetReq <= 1'b0;
    end else begin
      seen <= synced;
      if (evt[CH_DIV])  divSlow  <= xfer.divCode;
      if (evt[CH_LOAD]) loadSlow <= xfer.loadVal;
      if (hwStart)      running  <= 1'b1;
      if (!resetReq) begin
        if (evt[CH_CMD]) begin
          cnt    <= nextLoad;
          preCnt <= '0;
          if (xfer.cmdStart) running <= 1'b1;
        end else if (running) begin
          if (tick) begin
            preCnt <= '0;
            if (cnt == '0) resetReq <= 1'b1;
            else           cnt <= cnt - CNT_W'(1);
          end else begin
            preCnt <= preCnt + DIV_W'(1);
          end
        end
      end
    end
  end

  // R8: the reset request holds until the block is reset
  p_sticky_r8: assert property (@(posedge slowClk) disable iff (!rstN)
    resetReq |=> resetReq);
  // R6: expiry only from an empty running counter
  p_expire_zero_r6: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(resetReq) |-> ($past(cnt) == '0 && $past(running)));
  // R6: each divider tick removes exactly one count
  p_tick_dec_r6: assert property (@(posedge slowClk) disable iff (!rstN)
    (running && tick && cnt != '0 && !evt[CH_CMD] && !resetReq)
      |=> cnt == $past(cnt) - CNT_W'(1));
  // R12: no expiry without the watchdog running
  p_idle_quiet_r12: assert property (@(posedge slowClk) disable iff (!rstN)
    !running |=> !$rose(resetReq));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
(
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              hwStart,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  wrData,
  output logic [KEY_W-1:0]  rdData,
  output logic              resetReq
);
  xfer_t           xfer;
  logic [N_CH-1:0] ackTgl;

  wdog_regs u_regs (
    .busClk(busClk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .ackRaw(ackTgl), .rdData(rdData), .xfer(xfer)
  );

  wdog_counter u_counter (
    .slowClk(slowClk), .rstN(rstN), .hwStart(hwStart), .xfer(xfer),
    .ackTgl(ackTgl), .resetReq(resetReq)
  );
endmodule

// File: tb/wdog_top_tb.sv
`timescale 1ns/1ps
module wdog_top_tb;
  logic        busClk = 1'b0, slowClk = 1'b0;
  logic        rstN = 1'b0, hwStart = 1'b0, wrEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        resetReq;

  int nChecks = 0, nFail = 0, busCyc = 0;
  bit done = 0;

  always #2  busClk  = ~busClk;   // 250 MHz
  always #10 slowClk = ~slowClk;  // slow domain
  always @(posedge busClk) busCyc++;

  wdog_top u_dut (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN), .hwStart(hwStart),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .resetReq(resetReq)
  );

  // {req[3:0], kind[1:0] (0 write, 1 read, 2 wait idle), addr[1:0], data[15:0]}
  localparam int NV = 27;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 2'd1, 2'd1, 16'h0000},   // R1 divider reset value
    {4'd1, 2'd1, 2'd2, 16'h0FFF},   // R1 reload reset value
    {4'd1, 2'd1, 2'd3, 16'h0000},   // R1 status idle
    {4'd2, 2'd0, 2'd1, 16'h0005},   // R2 locked write
    {4'd2, 2'd1, 2'd1, 16'h0000},
    {4'd2, 2'd0, 2'd2, 16'h0123},
    {4'd2, 2'd1, 2'd2, 16'h0FFF},
    {4'd2, 2'd0, 2'd0, 16'h5555},   // unlock
    {4'd2, 2'd0, 2'd1, 16'h0003},
    {4'd2, 2'd1, 2'd1, 16'h0003},
    {4'd4, 2'd1, 2'd3, 16'h0001},   // R4 divider busy
    {4'd5, 2'd0, 2'd1, 16'h0006},   // R5 write while busy
    {4'd5, 2'd1, 2'd1, 16'h0003},
    {4'd11,2'd0, 2'd2, 16'h1005},   // R11 masking
    {4'd4, 2'd1, 2'd3, 16'h0003},   // R4 both in flight
    {4'd11,2'd1, 2'd2, 16'h0005},
    {4'd4, 2'd2, 2'd0, 16'h0000},
    {4'd4, 2'd1, 2'd3, 16'h0000},
    {4'd3, 2'd0, 2'd0, 16'h1234},   // R3 stray key relocks
    {4'd3, 2'd0, 2'd2, 16'h0777},
    {4'd3, 2'd1, 2'd2, 16'h0005},
    {4'd3, 2'd0, 2'd0, 16'h5555},
    {4'd10,2'd0, 2'd1, 16'h0007},   // R10 code 7 accepted
    {4'd10,2'd1, 2'd1, 16'h0007},
    {4'd3, 2'd2, 2'd0, 16'h0000},
    {4'd3, 2'd0, 2'd0, 16'hCCCC},   // start key also relocks
    {4'd3, 2'd1, 2'd1, 16'h0007}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge busClk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge busClk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge busClk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    for (int i = 0; i < 40; i++) begin
      busRead(2'd3, s);
      if (s == 16'h0) return;
      repeat (2) @(negedge busClk);
    end
  endtask

  task automatic doReset(input bit hw);
    @(negedge busClk);
    rstN = 1'b0; hwStart = hw; wrEn = 1'b0;
    repeat (6) @(negedge busClk);
    rstN = 1'b1;
  endtask

  task automatic waitSlow(input int n);
    repeat (n) @(posedge slowClk);
    @(negedge slowClk);
  endtask

  // count slow edges until resetReq and require lo..hi
  task automatic measure(input int lo, input int hi, input string req);
    int n = 0;
    while (n < hi + 20 && !resetReq) begin
      @(posedge slowClk); n++;
      @(negedge slowClk);
    end
    check(resetReq && n >= lo && n <= hi, req, n, lo);
  endtask

  task automatic armAndStart(input logic [15:0] code, input logic [15:0] load);
    busWrite(2'd0, 16'h5555);
    busWrite(2'd1, code);
    busWrite(2'd2, load);
    waitIdle();
    busWrite(2'd0, 16'hCCCC);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    wait (busCyc >= 190000);
    check(1'b0, "watchdog", busCyc, 0);
    finishRun();
  end

  initial begin
    logic [15:0] rd;
    doReset(1'b0);
    check(resetReq == 1'b0, "R1", resetReq, 0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  rq = VEC[v][23:20];
      logic [1:0]  kd = VEC[v][19:18];
      logic [1:0]  ad = VEC[v][17:16];
      logic [15:0] dt = VEC[v][15:0];
      if (kd == 2'd0) busWrite(ad, dt);
      else if (kd == 2'd2) waitIdle();
      else begin
        busRead(ad, rd);
        check(rd == dt, $sformatf("R%0d vec%0d", rq, v), rd, dt);
      end
    end

    // R1: no expiry without start; R12: refresh alone does not start
    doReset(1'b0);
    busWrite(2'd0, 16'h5555);
    busWrite(2'd2, 16'h0001);
    waitIdle();
    busWrite(2'd0, 16'hAAAA);
    waitSlow(200);
    check(resetReq == 1'b0, "R12", resetReq, 0);
    check(resetReq == 1'b0, "R1", resetReq, 0);

    // R4: busy flag lifetime in slow cycles
    doReset(1'b0);
    busWrite(2'd0, 16'h5555);
    busWrite(2'd2, 16'h0100);
    begin
      int n = 0;
      rd = 16'h2;
      while (rd != 16'h0 && n < 12) begin
        @(posedge slowClk); n++;
        busRead(2'd3, rd);
      end
      check(n >= 1 && n <= 5, "R4 busy time", n, 5);
    end

    // R6: reload 9, /4 -> 40 slow cycles
    doReset(1'b0);
    armAndStart(16'h0000, 16'h0009);
    measure(40, 45, "R6 /4");

    // R6 with overlapped updates: reload 3, /16 -> 64
    doReset(1'b0);
    armAndStart(16'h0002, 16'h0003);
    measure(64, 69, "R6 /16");

    // R10: code 7 acts as /256, reload 1 -> 512
    doReset(1'b0);
    armAndStart(16'h0007, 16'h0001);
    measure(512, 517, "R10 /256");

    // R7: periodic refresh keeps it alive, then expiry from last refresh
    doReset(1'b0);
    armAndStart(16'h0000, 16'h0009);
    for (int k = 0; k < 6; k++) begin
      waitSlow(20);
      check(resetReq == 1'b0, "R7 alive", resetReq, 0);
      busWrite(2'd0, 16'hAAAA);
    end
    measure(40, 45, "R7 after refresh");

    // R8: sticky, keys have no effect
    busWrite(2'd0, 16'hAAAA);
    busWrite(2'd0, 16'hCCCC);
    waitSlow(50);
    check(resetReq == 1'b1, "R8 sticky", resetReq, 1);
    doReset(1'b0);
    check(resetReq == 1'b0, "R8 cleared by reset", resetReq, 0);

    // R9: hardware start, default /4 and 0xFFF
    doReset(1'b1);
    waitSlow(16000);
    check(resetReq == 1'b0, "R9 early", resetReq, 0);
    measure(16380 - 16001, 16392 - 16001, "R9 expiry");
    hwStart = 1'b0;

    finishRun();
  end
endmodule